// File: doc/BRIEF.md
# Strided Block DMA Engine

This block copies data between a local pair of 4 KB memories and a large external memory. It can copy in either direction. A request has four parts: a local start address, an external start address, a two-bit direction code and a packed 32-bit shape word. The shape word describes a two-dimensional transfer. The transfer is a set of rows of equal byte length. An optional gap separates consecutive rows on the external side only. On the local side the addresses stay contiguous from one row to the next.

Every transfer is carried out in 64-bit beats. The engine issues at most one beat per cycle. For each beat it raises a read strobe on the source side. Two cycles later it raises a write strobe on the destination side, which carries the data the source returned. One further request can wait in a holding slot while a transfer runs. Two status outputs tell software when the engine is working and when the slot is occupied.

Local byte address bit 12 picks the target memory. Addresses below 0x1000 go to the data memory. Addresses from 0x1000 to 0x1FFF go to the instruction memory. Addresses and row lengths are handled in 8-byte units.

Top module: `dma_strided_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every read and write strobe is low, `stat_busy` and `stat_full` are low, and `req_ready` is high.
- R2: Direction code 1 copies inward. Each beat raises `ext_rd` with an external word address, and later writes the returned 64-bit word unchanged to the matching local word.
- R3: Direction code 2 copies outward. Each beat reads a local word through `dm_rd` or `im_rd`, and later writes the returned 64-bit word unchanged through `ext_wr` to the matching external word.
- R4: In the shape word, bits [11:0] give the row length in bytes, bits [19:12] give the number of extra rows, and bits [31:20] give the external gap in bytes. The transfer moves (extra rows + 1) rows. Each row has ceil(row length / 8) beats.
- R5: At each row end, the external address moves past the rounded row length plus the gap. For example, row length 0x20 with gap 8 starting at 0 puts the second row at 0x28. The low three bits of the gap are ignored. Local word addresses keep counting up without a break, wrapping at 8 KB.
- R6: Local byte address bit 12 routes a beat to the instruction memory (`im_rd`/`im_wr`) when 1 and to the data memory (`dm_rd`/`dm_wr`) when 0. The local word ports carry byte address bits [11:3]. The low three bits of both start addresses are ignored. At most one read strobe and at most one write strobe are high in any cycle.
- R7: Every write strobe comes exactly two cycles after the read strobe of its beat. With `ext_rdy` held high, beats follow one per cycle.
- R8: A read strobe is high in a cycle only if `ext_rdy` was high at the clock edge that began that cycle. Holding `ext_rdy` low stops new beats; beats already started still complete.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a transfer runs, one more request can be taken; it sets `stat_full` and drops `req_ready` until the engine starts it. A request offered while `req_ready` is low is dropped and has no effect.
- R10: `stat_busy` is high from the cycle after a valid request is taken until the cycle of its last write strobe. In the cycle after the last write strobe, with nothing queued, both `stat_busy` and `stat_full` are low.
- R11: A request whose direction code is 0 or 3 is discarded. It causes no strobe and does not raise either status flag.
- R12: A row length of 0 ends the transfer with no strobe. `stat_busy` returns low within two cycles of the request being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_dir | input | 2 | Direction: 1 = external to local, 2 = local to external |
| req_loc_addr | input | LOC_AW (13) | Local start byte address; bit 12 selects the instruction memory |
| req_ext_addr | input | EXT_AW (32) | External start byte address |
| req_shape | input | 32 | Shape word: gap [31:20], extra rows [19:12], row bytes [11:0] |
| req_ready | output | 1 | Holding slot empty; a request can be taken |
| stat_busy | output | 1 | Transfer active, queued or still draining |
| stat_full | output | 1 | Holding slot occupied |
| ext_rdy | input | 1 | External side can take a new beat |
| ext_rd | output | 1 | External read strobe |
| ext_rd_word | output | EXT_AW-3 | External read word address |
| ext_rdata | input | DW (64) | External read data, one cycle after `ext_rd` |
| ext_wr | output | 1 | External write strobe |
| ext_wr_word | output | EXT_AW-3 | External write word address |
| dm_rd | output | 1 | Data memory read strobe |
| im_rd | output | 1 | Instruction memory read strobe |
| loc_rd_word | output | LOC_AW-4 | Local read word address within the selected memory |
| dm_rdata | input | DW (64) | Data memory read data, one cycle after `dm_rd` |
| im_rdata | input | DW (64) | Instruction memory read data, one cycle after `im_rd` |
| dm_wr | output | 1 | Data memory write strobe |
| im_wr | output | 1 | Instruction memory write strobe |
| loc_wr_word | output | LOC_AW-4 | Local write word address within the selected memory |
| wr_data | output | DW (64) | Write data for whichever write strobe is high |

## Verification
A beat begins on the clock edge where the engine is active and `ext_rdy` is high. Its read strobe is visible in the following cycle. Its write strobe is visible exactly two cycles after that read strobe. `stat_busy` rises in the cycle after a request is taken and falls in the cycle after the last write strobe. The bench drives inputs and samples outputs on the falling edge. A scoreboard queue, filled by the request driver, is compared against each write strobe as it appears. A short read-strobe history confirms the two-cycle gap and confirms that no read strobe appears without `ext_rdy`. The status flags are checked one falling edge after each acceptance and one falling edge after each final write.

// File: rtl/dma_strided_pkg.sv
package dma_strided_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2,
    DIR_BAD  = 2'd3
  } dir_e;

  localparam int ROWLEN_W = 12;
  localparam int ROWCNT_W = 8;
  localparam int GAP_W    = 12;

  typedef struct packed {
    logic [GAP_W-1:0]    gap;
    logic [ROWCNT_W-1:0] rows;
    logic [ROWLEN_W-1:0] bytes;
  } shape_t;

  function automatic logic dir_ok(dir_e d);
    return (d == DIR_IN) || (d == DIR_OUT);
  endfunction

endpackage

// File: rtl/dma_req_slot.sv
module dma_req_slot
  import dma_strided_pkg::*;
#(
  parameter int LWW = 10,
  parameter int EWW = 29
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  dir_e           in_dir,
  input  logic [LWW-1:0] in_loc,
  input  logic [EWW-1:0] in_ext,
  input  shape_t         in_shape,
  output logic           in_ready,
  output logic           full,
  output dir_e           out_dir,
  output logic [LWW-1:0] out_loc,
  output logic [EWW-1:0] out_ext,
  output shape_t         out_shape,
  input  logic           pop
);

  logic take;
  assign take     = in_valid && !full && dir_ok(in_dir);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst)       full <= 1'b0;
    else if (pop)  full <= 1'b0;
    else if (take) full <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_dir   <= in_dir;
      out_loc   <= in_loc;
      out_ext   <= in_ext;
      out_shape <= in_shape;
    end
  end

endmodule

// File: rtl/dma_row_walker.sv
module dma_row_walker
  import dma_strided_pkg::*;
#(
  parameter int LWW = 10,
  parameter int EWW = 29,
  parameter int BL  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  dir_e           st_dir,
  input  logic [LWW-1:0] st_loc,
  input  logic [EWW-1:0] st_ext,
  input  shape_t         st_shape,
  input  logic           rdy,
  output logic           active,
  output logic           iss,
  output dir_e           iss_dir,
  output logic [LWW-1:0] iss_loc,
  output logic [EWW-1:0] iss_ext
);

  localparam int BW = ROWLEN_W - BL + 1;
  localparam int SW = GAP_W - BL;
  localparam logic [ROWLEN_W:0] ROUND = (ROWLEN_W+1)'((1 << BL) - 1);

  logic [ROWLEN_W:0]   rounded;
  logic [BW-1:0]       beats_st;
  logic [BW-1:0]       left_q, row_beats_q;
  logic [ROWCNT_W-1:0] rows_q;
  logic [SW-1:0]       skip_q;
  logic                row_end, last_beat;
  logic                unused_gap_lsb;

  assign rounded        = {1'b0, st_shape.bytes} + ROUND;
  assign beats_st       = rounded[ROWLEN_W:BL];
  assign unused_gap_lsb = ^st_shape.gap[BL-1:0];

  assign iss       = active && rdy;
  assign row_end   = (left_q == BW'(1));
  assign last_beat = row_end && (rows_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                   active <= 1'b0;
    else if (start)            active <= (beats_st != '0);
    else if (iss && last_beat) active <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      iss_dir     <= st_dir;
      iss_loc     <= st_loc;
      iss_ext     <= st_ext;
      left_q      <= beats_st;
      row_beats_q <= beats_st;
      rows_q      <= st_shape.rows;
      skip_q      <= st_shape.gap[GAP_W-1:BL];
    end else if (iss) begin
      iss_loc <= iss_loc + LWW'(1);
      if (row_end) begin
        left_q  <= row_beats_q;
        rows_q  <= rows_q - ROWCNT_W'(1);
        iss_ext <= iss_ext + EWW'(skip_q) + EWW'(1);
      end else begin
        left_q  <= left_q - BW'(1);
        iss_ext <= iss_ext + EWW'(1);
      end
    end
  end

endmodule

// File: rtl/dma_beat_pipe.sv
module dma_beat_pipe
  import dma_strided_pkg::*;
#(
  parameter int LWW = 10,
  parameter int EWW = 29,
  parameter int DW  = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iss,
  input  dir_e           iss_dir,
  input  logic [LWW-1:0] iss_loc,
  input  logic [EWW-1:0] iss_ext,
  input  logic [DW-1:0]  ext_rdata,
  input  logic [DW-1:0]  dm_rdata,
  input  logic [DW-1:0]  im_rdata,
  output logic           ext_rd,
  output logic [EWW-1:0] ext_rd_word,
  output logic           dm_rd,
  output logic           im_rd,
  output logic [LWW-2:0] loc_rd_word,
  output logic           ext_wr,
  output logic [EWW-1:0] ext_wr_word,
  output logic           dm_wr,
  output logic           im_wr,
  output logic [LWW-2:0] loc_wr_word,
  output logic [DW-1:0]  wr_data,
  output logic           busy
);

  localparam int SEL = LWW - 1;

  logic           s1_v, d_v;
  dir_e           s1_dir, d_dir;
  logic [LWW-1:0] s1_loc, d_loc;
  logic [EWW-1:0] d_ext;

  assign ext_rd_word = d_ext_src();
  assign loc_rd_word = s1_loc[LWW-2:0];

  function automatic logic [EWW-1:0] d_ext_src();
    return s1_ext_q;
  endfunction

  logic [EWW-1:0] s1_ext_q;

  // read stage: strobes registered from the issue decision
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      ext_rd <= 1'b0;
      dm_rd  <= 1'b0;
      im_rd  <= 1'b0;
    end else begin
      s1_v   <= iss;
      ext_rd <= iss && (iss_dir == DIR_IN);
      dm_rd  <= iss && (iss_dir == DIR_OUT) && !iss_loc[SEL];
      im_rd  <= iss && (iss_dir == DIR_OUT) &&  iss_loc[SEL];
    end
  end

  always_ff @(posedge clk) begin
    s1_dir   <= iss_dir;
    s1_loc   <= iss_loc;
    s1_ext_q <= iss_ext;
  end

  // data-return stage: memory answers during this cycle
  always_ff @(posedge clk) begin
    if (rst) d_v <= 1'b0;
    else     d_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    d_dir <= s1_dir;
    d_loc <= s1_loc;
    d_ext <= s1_ext_q;
  end

  // write stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_wr <= 1'b0;
      dm_wr  <= 1'b0;
      im_wr  <= 1'b0;
    end else begin
      ext_wr <= d_v && (d_dir == DIR_OUT);
      dm_wr  <= d_v && (d_dir == DIR_IN) && !d_loc[SEL];
      im_wr  <= d_v && (d_dir == DIR_IN) &&  d_loc[SEL];
    end
  end

  always_ff @(posedge clk) begin
    ext_wr_word <= d_ext;
    loc_wr_word <= d_loc[LWW-2:0];
    if (d_dir == DIR_IN)  wr_data <= ext_rdata;
    else if (d_loc[SEL])  wr_data <= im_rdata;
    else                  wr_data <= dm_rdata;
  end

  assign busy = s1_v || d_v || ext_wr || dm_wr || im_wr;

endmodule

// File: rtl/dma_strided_top.sv
module dma_strided_top
  import dma_strided_pkg::*;
#(
  parameter int LOC_AW = 13,
  parameter int EXT_AW = 32,
  parameter int DW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_dir,
  input  logic [LOC_AW-1:0] req_loc_addr,
  input  logic [EXT_AW-1:0] req_ext_addr,
  input  logic [31:0]       req_shape,
  output logic              req_ready,
  output logic              stat_busy,
  output logic              stat_full,
  input  logic              ext_rdy,
  output logic              ext_rd,
  output logic [EXT_AW-4:0] ext_rd_word,
  input  logic [DW-1:0]     ext_rdata,
  output logic              ext_wr,
  output logic [EXT_AW-4:0] ext_wr_word,
  output logic              dm_rd,
  output logic              im_rd,
  output logic [LOC_AW-5:0] loc_rd_word,
  input  logic [DW-1:0]     dm_rdata,
  input  logic [DW-1:0]     im_rdata,
  output logic              dm_wr,
  output logic              im_wr,
  output logic [LOC_AW-5:0] loc_wr_word,
  output logic [DW-1:0]     wr_data
);

  localparam int BL  = $clog2(DW / 8);
  localparam int LWW = LOC_AW - BL;
  localparam int EWW = EXT_AW - BL;

  dir_e           q_dir, w_dir;
  logic [LWW-1:0] q_loc, w_loc;
  logic [EWW-1:0] q_ext, w_ext;
  shape_t         q_shape;
  logic           q_full, walk_active, start, iss, pipe_busy;
  logic           unused_lsb;

  assign unused_lsb = ^{req_loc_addr[BL-1:0], req_ext_addr[BL-1:0]};
  assign start      = q_full && !walk_active;

  dma_req_slot #(.LWW(LWW), .EWW(EWW)) slot_i (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_dir(dir_e'(req_dir)),
    .in_loc(req_loc_addr[LOC_AW-1:BL]), .in_ext(req_ext_addr[EXT_AW-1:BL]),
    .in_shape(shape_t'(req_shape)), .in_ready(req_ready),
    .full(q_full), .out_dir(q_dir), .out_loc(q_loc), .out_ext(q_ext),
    .out_shape(q_shape), .pop(start)
  );

  dma_row_walker #(.LWW(LWW), .EWW(EWW), .BL(BL)) walk_i (
    .clk(clk), .rst(rst), .start(start),
    .st_dir(q_dir), .st_loc(q_loc), .st_ext(q_ext), .st_shape(q_shape),
    .rdy(ext_rdy), .active(walk_active), .iss(iss),
    .iss_dir(w_dir), .iss_loc(w_loc), .iss_ext(w_ext)
  );

  dma_beat_pipe #(.LWW(LWW), .EWW(EWW), .DW(DW)) pipe_i (
    .clk(clk), .rst(rst), .iss(iss),
    .iss_dir(w_dir), .iss_loc(w_loc), .iss_ext(w_ext),
    .ext_rdata(ext_rdata), .dm_rdata(dm_rdata), .im_rdata(im_rdata),
    .ext_rd(ext_rd), .ext_rd_word(ext_rd_word),
    .dm_rd(dm_rd), .im_rd(im_rd), .loc_rd_word(loc_rd_word),
    .ext_wr(ext_wr), .ext_wr_word(ext_wr_word),
    .dm_wr(dm_wr), .im_wr(im_wr), .loc_wr_word(loc_wr_word),
    .wr_data(wr_data), .busy(pipe_busy)
  );

  assign stat_full = q_full;
  assign stat_busy = q_full || walk_active || pipe_busy;

endmodule

// File: rtl/dma_strided_chk.sv
module dma_strided_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_dir,
  input logic       req_ready,
  input logic       stat_busy,
  input logic       stat_full,
  input logic       ext_rdy,
  input logic       ext_rd,
  input logic       dm_rd,
  input logic       im_rd,
  input logic       ext_wr,
  input logic       dm_wr,
  input logic       im_wr
);

  logic any_rd, any_wr, dir_valid;
  assign any_rd    = ext_rd || dm_rd || im_rd;
  assign any_wr    = ext_wr || dm_wr || im_wr;
  assign dir_valid = (req_dir == 2'd1) || (req_dir == 2'd2);

  p_rd_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_rd, dm_rd, im_rd}));

  p_wr_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_wr, dm_wr, im_wr}));

  p_rd_to_wr_r7: assert property (@(posedge clk) disable iff (rst)
    any_rd |-> ##2 any_wr);

  p_inward_pair_r2: assert property (@(posedge clk) disable iff (rst)
    ext_rd |-> ##2 (dm_wr || im_wr));

  p_outward_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (dm_rd || im_rd) |-> ##2 ext_wr);

  p_rdy_gate_r8: assert property (@(posedge clk) disable iff (rst)
    any_rd |-> $past(ext_rdy));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !stat_busy |-> !(any_rd || any_wr));

  p_busy_after_take_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && dir_valid) |=> stat_busy);

  p_bad_dir_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dir_valid && !stat_busy) |=> !stat_full);

endmodule

bind dma_strided_top dma_strided_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
  .req_ready(req_ready), .stat_busy(stat_busy), .stat_full(stat_full),
  .ext_rdy(ext_rdy), .ext_rd(ext_rd), .dm_rd(dm_rd), .im_rd(im_rd),
  .ext_wr(ext_wr), .dm_wr(dm_wr), .im_wr(im_wr)
);

// File: tb/dma_strided_top_tb_top.sv
module dma_strided_top_tb_top;

  localparam int LOC_AW = 13;
  localparam int EXT_AW = 32;
  localparam int DW     = 64;
  localparam int LWW    = LOC_AW - 3;
  localparam int EWW    = EXT_AW - 3;

  logic              clk, rst;
  logic              req_valid;
  logic [1:0]        req_dir;
  logic [LOC_AW-1:0] req_loc_addr;
  logic [EXT_AW-1:0] req_ext_addr;
  logic [31:0]       req_shape;
  logic              req_ready, stat_busy, stat_full;
  logic              ext_rdy;
  logic              ext_rd, ext_wr, dm_rd, im_rd, dm_wr, im_wr;
  logic [EWW-1:0]    ext_rd_word, ext_wr_word;
  logic [LWW-2:0]    loc_rd_word, loc_wr_word;
  logic [DW-1:0]     ext_rdata, dm_rdata, im_rdata, wr_data;

  dma_strided_top #(.LOC_AW(LOC_AW), .EXT_AW(EXT_AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
    .req_loc_addr(req_loc_addr), .req_ext_addr(req_ext_addr),
    .req_shape(req_shape), .req_ready(req_ready),
    .stat_busy(stat_busy), .stat_full(stat_full), .ext_rdy(ext_rdy),
    .ext_rd(ext_rd), .ext_rd_word(ext_rd_word), .ext_rdata(ext_rdata),
    .ext_wr(ext_wr), .ext_wr_word(ext_wr_word),
    .dm_rd(dm_rd), .im_rd(im_rd), .loc_rd_word(loc_rd_word),
    .dm_rdata(dm_rdata), .im_rdata(im_rdata),
    .dm_wr(dm_wr), .im_wr(im_wr), .loc_wr_word(loc_wr_word),
    .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] ext_pat(logic [EWW-1:0] w);
    return {3'b101, w, 32'h5A5A0000 ^ {3'b000, w}};
  endfunction

  function automatic logic [63:0] loc_pat(logic [LWW-1:0] w);
    return {w, 22'h15A3C, ~{22'h0, w}};
  endfunction

  // sources with one-cycle read latency
  always @(posedge clk) begin
    if (ext_rd) ext_rdata <= ext_pat(ext_rd_word);
    if (dm_rd)  dm_rdata  <= loc_pat({1'b0, loc_rd_word});
    if (im_rd)  im_rdata  <= loc_pat({1'b1, loc_rd_word});
  end

  typedef struct packed {
    logic        is_ext;
    logic [31:0] addr;
    logic [63:0] data;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ready driver: changes after the falling edge
  initial begin
    ext_rdy = 1'b1;
    forever begin
      @(negedge clk);
      #2;
      if (rdy_mode) begin
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ext_rdy = lfsr[0] | lfsr[3];
      end else begin
        ext_rdy = 1'b1;
      end
    end
  end

  // monitor: compares writes against the scoreboard
  initial begin
    bit h1, h2;
    h1 = 0; h2 = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        h1 = 0; h2 = 0;
      end else begin
        bit any_rd, any_wr;
        any_rd = ext_rd | dm_rd | im_rd;
        any_wr = ext_wr | dm_wr | im_wr;
        if (any_rd)
          chk(ext_rdy == 1'b1, "R8", "read strobe without ready", 64'(ext_rdy), 64'd1);
        if (any_wr) begin
          chk(h2, "R7", "write not two cycles after read", 64'(h2), 64'd1);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9/R11", "unexpected write", 64'(ext_wr ? ext_wr_word : loc_wr_word), 64'd0);
          end else begin
            item_t it;
            string tg;
            logic [31:0] act_addr;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            act_addr = ext_wr ? {3'b000, ext_wr_word} : {22'h0, im_wr, loc_wr_word};
            chk(ext_wr == it.is_ext, tg, "write side", 64'(ext_wr), 64'(it.is_ext));
            chk(act_addr == it.addr, tg, "write address", 64'(act_addr), 64'(it.addr));
            chk(wr_data == it.data, tg, "write data", wr_data, it.data);
          end
        end
        h2 = h1;
        h1 = any_rd;
      end
    end
  end

  task automatic send(input logic [1:0] d, input logic [12:0] la,
                      input logic [31:0] ea, input logic [31:0] shp,
                      input string tag);
    int beats, rows, gapw;
    logic [LWW-1:0] lw;
    logic [EWW-1:0] row_base;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid    = 1'b1;
    req_dir      = d;
    req_loc_addr = la;
    req_ext_addr = ea;
    req_shape    = shp;
    if (d == 2'd1 || d == 2'd2) begin
      beats    = (int'(shp[11:0]) + 7) >> 3;
      rows     = int'(shp[19:12]) + 1;
      gapw     = int'(shp[31:23]);
      lw       = la[12:3];
      row_base = ea[31:3];
      for (int r = 0; r < rows; r++) begin
        for (int b = 0; b < beats; b++) begin
          item_t it;
          logic [EWW-1:0] ew;
          ew = row_base + EWW'(b);
          if (d == 2'd1) begin
            it.is_ext = 1'b0;
            it.addr   = {22'h0, lw};
            it.data   = ext_pat(ew);
          end else begin
            it.is_ext = 1'b1;
            it.addr   = {3'b000, ew};
            it.data   = loc_pat(lw);
          end
          exp_q.push_back(it);
          tag_q.push_back(tag);
          lw = lw + LWW'(1);
        end
        row_base = row_base + EWW'(beats) + EWW'(gapw);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (d == 2'd1 || d == 2'd2)
      chk(stat_busy == 1'b1, "R10", "busy after accept", 64'(stat_busy), 64'd1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(stat_busy == 1'b0, "R10", "busy clear after last write", 64'(stat_busy), 64'd0);
    chk(stat_full == 1'b0, "R10", "full clear after last write", 64'(stat_full), 64'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_dir = 2'd0;
    req_loc_addr = '0; req_ext_addr = '0; req_shape = '0;
    repeat (4) @(negedge clk);
    chk(!(ext_rd | dm_rd | im_rd | ext_wr | dm_wr | im_wr), "R1", "strobes in reset", 64'd1, 64'd0);
    chk(stat_busy == 1'b0 && stat_full == 1'b0, "R1", "flags in reset", 64'({stat_busy, stat_full}), 64'd0);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(stat_busy == 1'b0 && req_ready == 1'b1, "R1", "idle after reset", 64'({stat_busy, req_ready}), 64'd1);

    send(2'd1, 13'h0000, 32'h0000_0000, 32'h0000_1010, "R2 R4"); drain();
    send(2'd2, 13'h0000, 32'h0000_0100, 32'h0000_0020, "R3"); drain();
    send(2'd1, 13'h1000, 32'h0000_0000, 32'h0000_1010, "R6"); drain();
    send(2'd2, 13'h1000, 32'h0001_0200, 32'h0000_0010, "R6"); drain();
    send(2'd1, 13'h1100, 32'h0000_0000, 32'h0080_1020, "R5"); drain();
    send(2'd2, 13'h1100, 32'h0001_0400, 32'h0080_1010, "R5"); drain();
    send(2'd1, 13'h0007, 32'h0000_0105, 32'h0000_0013, "R4 R6"); drain();
    send(2'd2, 13'h1FF8, 32'h0000_2000, 32'h00F0_1010, "R5 R6"); drain();

    rdy_mode = 1'b1;
    send(2'd1, 13'h0400, 32'h0000_3000, 32'h0100_2040, "R8"); drain();
    send(2'd2, 13'h1400, 32'h0000_5000, 32'h0000_1018, "R8"); drain();
    rdy_mode = 1'b0;

    send(2'd1, 13'h0200, 32'h0000_4000, 32'h0000_3080, "R9");
    repeat (2) @(negedge clk);
    chk(stat_full == 1'b0, "R9", "slot empty while first runs", 64'(stat_full), 64'd0);
    send(2'd2, 13'h1200, 32'h0000_8000, 32'h0000_0040, "R9");
    chk(stat_full == 1'b1, "R9", "full with one queued", 64'(stat_full), 64'd1);
    chk(req_ready == 1'b0, "R9", "ready low when full", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_dir = 2'd1; req_loc_addr = 13'h0300;
    req_ext_addr = 32'h0000_9000; req_shape = 32'h0000_0010;
    @(negedge clk);
    req_valid = 1'b0;
    chk(stat_full == 1'b1, "R9", "offer while full dropped", 64'(stat_full), 64'd1);
    drain();

    send(2'd0, 13'h0000, 32'h0000_0000, 32'h0000_0010, "R11");
    chk(stat_busy == 1'b0 && stat_full == 1'b0, "R11", "dir 0 discarded", 64'({stat_busy, stat_full}), 64'd0);
    send(2'd3, 13'h0000, 32'h0000_0000, 32'h0000_0010, "R11");
    chk(stat_busy == 1'b0 && stat_full == 1'b0, "R11", "dir 3 discarded", 64'({stat_busy, stat_full}), 64'd0);
    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after discard", 64'(req_ready), 64'd1);

    send(2'd1, 13'h0040, 32'h0000_0040, 32'h0000_5000, "R12");
    @(negedge clk);
    chk(stat_busy == 1'b0, "R12", "zero-length done", 64'(stat_busy), 64'd0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && stat_busy == 1'b0, "R12", "no strobes", 64'(stat_busy), 64'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule